// File: doc/BRIEF.md
# Time-Multiplexed 2D Convolution Multiply-Accumulate

This block forms one output sample of a two-dimensional convolution: a window of unsigned 8-bit pixels is multiplied tap by tap against signed 8-bit weights held in an internal weight store, and the products are summed at 32-bit precision. A row of four multipliers is reused across one, two or four clock cycles per output sample. Each extra pass adds four more taps to the window, so the window holds 4, 8 or 16 taps. The price is that the sample rate drops by the same factor.

A pulse on `start_i` captures the whole 16-tap window, the pass count and the gain setting. The block then steps through its passes and clears the running sum on the first one. On the last pass it adds a 32-bit partial sum from an upstream stage, which lets several blocks be chained to build a larger kernel. The total is shifted left by 0 to 15 places so that its useful bits sit near the top of the word. It then appears on `result_o` together with a one-cycle `valid_o` strobe. Weights are written one at a time through a simple write port while the block is idle.

Top module: `conv_mac`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `valid_o` is 0 and `result_o` is 0. All 16 weights reset to 0, so a first result with no weights written equals the cascade value shifted by the gain.
- R2: `mode_i` selects the number of passes: 0 gives one pass (taps 0..3), 1 gives two passes (taps 0..7), and 2 or 3 gives four passes (taps 0..15). Tap j is `win_i[8j+7:8j]` and is multiplied by the weight at address j.
- R3: Pixels are unsigned and weights are two's complement. The sum of the products, plus the cascade value, is taken modulo 2^32.
- R4: `casc_i` is added exactly once to each result. It is sampled at the clock edge that completes the final pass.
- R5: The 32-bit total is shifted left by `gain_i` places (0..15). Bits that leave the top are dropped and zeros enter at the bottom, with no saturation.
- R6: `valid_o` is high for one cycle, N+1 clock edges after the edge that samples `start_i`, where N is the number of passes. `result_o` holds its value until the next strobe.
- R7: The window, the mode and the gain are captured at the start edge. Later changes to these inputs do not affect the result in progress.
- R8: When `coef_we_i` is high, `coef_data_i` is written to address `coef_addr_i` (0..15) at that clock edge. The new weight is used by every later window.
- R9: A new `start_i` may be given in the cycle of the final pass. The next window then begins without a gap, and in one-pass mode a result is produced every cycle.
- R10: The running sum clears on the first pass of each window, so nothing carries over from one result to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | MAC clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | First cycle of a pixel period; captures window, mode and gain |
| win_i | input | 128 | 16 window taps, tap j in bits 8j+7:8j |
| mode_i | input | 2 | Pass count select (0: one, 1: two, 2/3: four) |
| gain_i | input | 4 | Left shift applied to the result |
| coef_we_i | input | 1 | Weight write enable |
| coef_addr_i | input | 4 | Weight address (tap index) |
| coef_data_i | input | 8 | Weight value, two's complement |
| casc_i | input | 32 | Partial sum from an upstream stage |
| result_o | output | 32 | Aligned convolution result |
| valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The assertions assume that `start_i` arrives only when the block is idle or in its final pass, because an earlier restart would cut a window short and break the fixed latency they check. They also assume that weights are written only between windows. The stimulus keeps both rules. It issues each new window only after the previous one has reached its last pass, and it writes weights only after all pending results have come out. It also changes the window, mode and gain freely in the cycles after a start, to show that none of those changes reaches the result.

// File: rtl/conv_mac_pkg.sv
package conv_mac_pkg;
  localparam int MAX_PH = 4;
  localparam int PH_W   = $clog2(MAX_PH);

  typedef enum logic [1:0] {
    MODE_X1  = 2'd0,
    MODE_X2  = 2'd1,
    MODE_X4  = 2'd2,
    MODE_X4A = 2'd3
  } mode_e;

  function automatic logic [PH_W-1:0] last_phase(input logic [1:0] m);
    case (mode_e'(m))
      MODE_X1: return PH_W'(0);
      MODE_X2: return PH_W'(1);
      default: return PH_W'(MAX_PH - 1);
    endcase
  endfunction
endpackage

// File: rtl/conv_coef_store.sv
module conv_coef_store #(
  parameter int TAPS   = 16,
  parameter int COEF_W = 8,
  localparam int ADDR_W = $clog2(TAPS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [COEF_W-1:0]        data_i,
  output logic [TAPS*COEF_W-1:0]   coef_o
);
  for (genvar k = 0; k < TAPS; k++) begin : g_ent
    logic [COEF_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              q <= '0;
      else if (we_i && addr_i == ADDR_W'(k))    q <= data_i;
    end
    assign coef_o[k*COEF_W +: COEF_W] = q;
  end
endmodule

// File: rtl/conv_mac_lanes.sv
module conv_mac_lanes #(
  parameter int LANES  = 4,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 32,
  localparam int PROD_W = PIX_W + COEF_W + 1
) (
  input  logic [LANES*PIX_W-1:0]  pix_i,
  input  logic [LANES*COEF_W-1:0] coef_i,
  output logic [ACC_W-1:0]        psum_o
);
  logic [ACC_W-1:0] prod_ext [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic signed [PIX_W:0]    pix_s;
    logic signed [COEF_W-1:0] coef_s;
    logic signed [PROD_W-1:0] prod;
    assign pix_s  = $signed({1'b0, pix_i[i*PIX_W +: PIX_W]});
    assign coef_s = $signed(coef_i[i*COEF_W +: COEF_W]);
    assign prod   = pix_s * coef_s;
    // sign-extend product into accumulator width
    assign prod_ext[i] = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  end

  always_comb begin
    psum_o = '0;
    for (int i = 0; i < LANES; i++) psum_o = psum_o + prod_ext[i];
  end
endmodule

// File: rtl/conv_acc_ctrl.sv
module conv_acc_ctrl
  import conv_mac_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int PIX_W  = 8,
  parameter int ACC_W  = 32,
  parameter int GAIN_W = 4,
  localparam int GRP_W = LANES * PIX_W,
  localparam int WIN_W = GRP_W * MAX_PH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WIN_W-1:0]  win_i,
  input  logic [1:0]        mode_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [ACC_W-1:0]  casc_i,
  input  logic [ACC_W-1:0]  psum_i,
  output logic [GRP_W-1:0]  lane_pix_o,
  output logic [PH_W-1:0]   phase_o,
  output logic [PH_W-1:0]   last_o,
  output logic              active_o,
  output logic              done_o,
  output logic [ACC_W-1:0]  acc_o,
  output logic [GAIN_W-1:0] gain_o
);
  logic [WIN_W-1:0]  win_q;
  logic [PH_W-1:0]   phase_q, last_q;
  logic              active_q, done_q;
  logic [ACC_W-1:0]  acc_q;
  logic [GAIN_W-1:0] gain_q, gain_done_q;
  logic              first_ph, final_ph;

  assign first_ph   = (phase_q == '0);
  assign final_ph   = (phase_q == last_q);
  assign lane_pix_o = win_q[int'(phase_q)*GRP_W +: GRP_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q       <= '0;
      phase_q     <= '0;
      last_q      <= '0;
      active_q    <= 1'b0;
      done_q      <= 1'b0;
      acc_q       <= '0;
      gain_q      <= '0;
      gain_done_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (active_q) begin
        acc_q <= (first_ph ? '0 : acc_q) + psum_i + (final_ph ? casc_i : '0);
        if (final_ph) begin
          done_q      <= 1'b1;
          active_q    <= 1'b0;
          gain_done_q <= gain_q;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
      if (start_i) begin
        win_q    <= win_i;
        last_q   <= last_phase(mode_i);
        gain_q   <= gain_i;
        phase_q  <= '0;
        active_q <= 1'b1;
      end
    end
  end

  assign phase_o  = phase_q;
  assign last_o   = last_q;
  assign active_o = active_q;
  assign done_o   = done_q;
  assign acc_o    = acc_q;
  assign gain_o   = gain_done_q;
endmodule

// File: rtl/conv_gain_shift.sv
module conv_gain_shift #(
  parameter int ACC_W  = 32,
  parameter int GAIN_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [ACC_W-1:0]  result_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= done_i;
      if (done_i) result_o <= acc_i << gain_i;
    end
  end
endmodule

// File: rtl/conv_mac.sv
module conv_mac
  import conv_mac_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 32,
  parameter int GAIN_W = 4,
  localparam int TAPS   = LANES * MAX_PH,
  localparam int ADDR_W = $clog2(TAPS),
  localparam int WIN_W  = TAPS * PIX_W,
  localparam int CGRP_W = LANES * COEF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WIN_W-1:0]  win_i,
  input  logic [1:0]        mode_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic              coef_we_i,
  input  logic [ADDR_W-1:0] coef_addr_i,
  input  logic [COEF_W-1:0] coef_data_i,
  input  logic [ACC_W-1:0]  casc_i,
  output logic [ACC_W-1:0]  result_o,
  output logic              valid_o
);
  logic [TAPS*COEF_W-1:0]  coef_flat;
  logic [LANES*PIX_W-1:0]  lane_pix;
  logic [CGRP_W-1:0]       lane_coef;
  logic [ACC_W-1:0]        psum, acc;
  logic [PH_W-1:0]         phase, last_ph;
  logic                    active, done;
  logic [GAIN_W-1:0]       gain_done;

  conv_coef_store #(.TAPS(TAPS), .COEF_W(COEF_W)) u_store (
    .clk_i, .rst_ni,
    .we_i(coef_we_i), .addr_i(coef_addr_i), .data_i(coef_data_i),
    .coef_o(coef_flat)
  );

  assign lane_coef = coef_flat[int'(phase)*CGRP_W +: CGRP_W];

  conv_mac_lanes #(.LANES(LANES), .PIX_W(PIX_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_lanes (
    .pix_i(lane_pix), .coef_i(lane_coef), .psum_o(psum)
  );

  conv_acc_ctrl #(.LANES(LANES), .PIX_W(PIX_W), .ACC_W(ACC_W), .GAIN_W(GAIN_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .win_i, .mode_i, .gain_i, .casc_i,
    .psum_i(psum), .lane_pix_o(lane_pix), .phase_o(phase), .last_o(last_ph),
    .active_o(active), .done_o(done), .acc_o(acc), .gain_o(gain_done)
  );

  conv_gain_shift #(.ACC_W(ACC_W), .GAIN_W(GAIN_W)) u_gain (
    .clk_i, .rst_ni, .done_i(done), .acc_i(acc), .gain_i(gain_done),
    .result_o, .valid_o
  );
endmodule

// File: rtl/conv_mac_chk.sv
module conv_mac_chk #(
  parameter int ACC_W  = 32,
  parameter int GAIN_W = 4,
  parameter int PH_W   = 2,
  parameter int CF_W   = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [1:0]        mode_i,
  input logic              coef_we_i,
  input logic              valid_o,
  input logic [ACC_W-1:0]  result_o,
  input logic [PH_W-1:0]   phase,
  input logic [PH_W-1:0]   last_ph,
  input logic              active,
  input logic [GAIN_W-1:0] gain_done,
  input logic [CF_W-1:0]   coef_flat
);
  always @(negedge clk_i)
    if (!rst_ni) p_reset_out_r1: assert (!valid_o && result_o == '0);

  p_phase_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> phase <= last_ph);

  p_low_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (result_o & ((ACC_W'(1) << $past(gain_done)) - ACC_W'(1))) == '0);

  p_lat_x1_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && mode_i == 2'd0 |-> ##3 valid_o);

  p_lat_x2_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && mode_i == 2'd1 |-> ##4 valid_o);

  p_lat_x4_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && mode_i[1] |-> ##6 valid_o);

  p_coef_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !coef_we_i |=> $stable(coef_flat));
endmodule

bind conv_mac conv_mac_chk #(
  .ACC_W(ACC_W), .GAIN_W(GAIN_W), .PH_W(conv_mac_pkg::PH_W), .CF_W(TAPS*COEF_W)
) u_chk (
  .clk_i, .rst_ni, .start_i, .mode_i, .coef_we_i, .valid_o, .result_o,
  .phase, .last_ph, .active, .gain_done, .coef_flat
);

// File: tb/conv_mac_bench.sv
module conv_mac_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] win_i = '0;
  logic [1:0]   mode_i = '0;
  logic [3:0]   gain_i = '0;
  logic         coef_we_i = 1'b0;
  logic [3:0]   coef_addr_i = '0;
  logic [7:0]   coef_data_i = '0;
  logic [31:0]  casc_i = '0;
  logic [31:0]  result_o;
  logic         valid_o;

  conv_mac u_conv_mac (.*);

  always #10 clk_i = ~clk_i;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 1'b0;
  string req = "R1";
  logic signed [7:0] cm [16];
  logic [31:0] pend_casc = '0;
  int          due_q [$];
  logic [31:0] val_q [$];

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic int passes(input logic [1:0] m);
    return (m == 2'd0) ? 1 : (m == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] ref_calc(input logic [1:0] m, input logic [3:0] g,
                                           input logic [127:0] w, input logic [31:0] c);
    longint s = 0;
    logic [31:0] r;
    for (int j = 0; j < passes(m) * 4; j++)
      s += longint'(w[8*j +: 8]) * longint'(cm[j]);
    s += longint'(c);
    r = s[31:0];
    return r << g;
  endfunction

  // per-cycle comparison against the queued expectation
  always @(negedge clk_i) begin
    if (!finished) begin
      n_cmp++;
      if (!rst_ni) begin
        if (valid_o !== 1'b0 || result_o !== 32'd0) begin
          n_bad++;
          $display("FAIL R1 reset: valid=%0b result=%h expected 0/0", valid_o, result_o);
        end
      end else if (due_q.size() > 0 && due_q[0] == cyc) begin
        if (valid_o !== 1'b1 || result_o !== val_q[0]) begin
          n_bad++;
          $display("FAIL %s cyc %0d: valid=%0b result=%h expected 1/%h",
                   req, cyc, valid_o, result_o, val_q[0]);
        end
        void'(due_q.pop_front());
        void'(val_q.pop_front());
      end else if (valid_o !== 1'b0) begin
        n_bad++;
        $display("FAIL %s/R6 cyc %0d: valid=%0b expected 0", req, cyc, valid_o);
      end
    end
  end

  task automatic tick(input bit st, input logic [1:0] m, input logic [3:0] g,
                      input logic [127:0] w, input logic [31:0] c);
    @(negedge clk_i);
    #1;
    start_i = st; mode_i = m; gain_i = g; win_i = w; coef_we_i = 1'b0;
    casc_i = pend_casc;               // cascade lags start by one cycle (R4)
    if (st) begin
      pend_casc = c;
      due_q.push_back(cyc + 1 + passes(m) + 1);
      val_q.push_back(ref_calc(m, g, w, c));
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) tick(1'b0, mode_i, gain_i, win_i, 32'd0);
  endtask

  // issue one window, then idle until its final pass (gap extra idle cycles)
  task automatic pix(input logic [1:0] m, input logic [3:0] g,
                     input logic [127:0] w, input logic [31:0] c, input int gap);
    tick(1'b1, m, g, w, c);
    idle(passes(m) - 1 + gap);
  endtask

  task automatic wcoef(input int a, input logic [7:0] d);
    @(negedge clk_i);
    #1;
    start_i = 1'b0; coef_we_i = 1'b1; coef_addr_i = 4'(a); coef_data_i = d;
    casc_i = pend_casc;
    cm[a] = d;
  endtask

  function automatic logic [127:0] rand_win();
    logic [127:0] w;
    for (int i = 0; i < 4; i++) w[32*i +: 32] = $urandom;
    return w;
  endfunction

  function automatic logic [127:0] ramp_win(input int base);
    logic [127:0] w;
    for (int j = 0; j < 16; j++) w[8*j +: 8] = 8'(base + j);
    return w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < 16; j++) cm[j] = '0;
    req = "R1";
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    idle(3);
    // R1: all weights zero, result is cascade only
    pix(2'd2, 4'd0, ramp_win(7), 32'h0000_1234, 3);
    pix(2'd0, 4'd4, ramp_win(9), 32'h0000_0005, 3);

    // R8: load weights, including extremes
    req = "R8";
    for (int j = 0; j < 16; j++) wcoef(j, (j == 3) ? 8'h80 : (j == 5) ? 8'h7f : 8'(j - 6));
    idle(1);
    pix(2'd2, 4'd0, ramp_win(1), 32'd0, 3);

    // R2: mode selects 4, 8 or 16 taps
    req = "R2";
    for (int j = 0; j < 16; j++) wcoef(j, 8'd1);
    idle(1);
    for (int m = 0; m < 4; m++) pix(2'(m), 4'd0, ramp_win(1), 32'd0, 2);
    pix(2'd2, 4'd0, {16{8'hff}}, 32'd0, 2);

    // R3: signed weights, unsigned pixels, wrap modulo 2^32
    req = "R3";
    for (int j = 0; j < 16; j++) wcoef(j, 8'h80);
    idle(1);
    pix(2'd2, 4'd0, {16{8'hff}}, 32'd0, 2);
    pix(2'd2, 4'd0, {16{8'hff}}, 32'h0000_1000, 2);
    for (int j = 0; j < 16; j++) wcoef(j, 8'h7f);
    idle(1);
    pix(2'd2, 4'd0, {16{8'hff}}, 32'hffff_ff00, 2);

    // R4: cascade across modes
    req = "R4";
    for (int m = 0; m < 3; m++) pix(2'(m), 4'd0, ramp_win(3), 32'h8000_0001, 2);

    // R5: gain extremes and bits dropped at the top
    req = "R5";
    pix(2'd1, 4'd0, ramp_win(20), 32'h1357_9bdf, 2);
    pix(2'd1, 4'd7, ramp_win(20), 32'h1357_9bdf, 2);
    pix(2'd1, 4'd15, ramp_win(20), 32'hf357_9bdf, 2);

    // R7: inputs scrambled right after the start edge
    req = "R7";
    tick(1'b1, 2'd2, 4'd3, ramp_win(40), 32'd77);
    for (int i = 0; i < 6; i++) tick(1'b0, 2'(i), 4'(i * 5), rand_win(), 32'd0);
    tick(1'b1, 2'd0, 4'd1, ramp_win(50), 32'd9);
    for (int i = 0; i < 4; i++) tick(1'b0, 2'd2, 4'd15, rand_win(), 32'd0);

    // R9: back-to-back streams with random weights
    req = "R9";
    for (int j = 0; j < 16; j++) wcoef(j, 8'($urandom));
    idle(1);
    for (int i = 0; i < 24; i++) pix(2'd0, 4'(i % 16), rand_win(), $urandom, 0);
    for (int i = 0; i < 8; i++) pix(2'd1, 4'(i), rand_win(), $urandom, 0);
    for (int i = 0; i < 8; i++) pix(2'(2 + i % 2), 4'(i + 2), rand_win(), $urandom, 0);
    idle(4);

    // R10: no carry-over between consecutive windows
    req = "R10";
    pix(2'd2, 4'd0, {16{8'hff}}, 32'd100, 0);
    pix(2'd2, 4'd0, '0, 32'd0, 0);
    pix(2'd0, 4'd0, {16{8'hff}}, 32'd0, 0);
    pix(2'd0, 4'd0, '0, 32'd1, 0);
    idle(4);

    // R8: rewrite one weight between windows
    req = "R8";
    pix(2'd0, 4'd0, ramp_win(2), 32'd0, 3);
    wcoef(2, 8'h9c);
    idle(1);
    pix(2'd0, 4'd0, ramp_win(2), 32'd0, 3);
    idle(4);

    if (due_q.size() != 0) begin
      n_bad++;
      $display("FAIL R6: %0d results never strobed, expected 0", due_q.size());
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule